// File: doc/BRIEF.md
# Configurable Logic Slice

The block is a soft model of one logic slice of a programmable fabric. It holds two identical cells. Each cell has a 4-input lookup table of 16 bits, a carry and sum path, and a storage element. The storage element is either placed in the output path or bypassed. A wide-function multiplexer joins the two table outputs, so the slice can realise any 5-input function. Each table has three modes. It can be plain combinational logic, a 16x1 synchronous RAM with asynchronous read, or a 16-bit shift register with an addressable tap.

All configuration enters through one serial port. This covers both tables and the control bits of each cell. While the load enable is high, each clock shifts in one bit, most significant first. A synchronous reset clears only the storage elements. The tables and control bits keep their values, so a configured slice survives a reset.

Top module: `cfg_logic_slice`

## Requirements
- R1: While `cfg_en` is high, each rising clock shifts `cfg_din` into a 40-bit chain that is sent most significant bit first as {cell1 word, cell0 word}. Each 20-bit word is laid out as bits [19:18] mode (0 logic, 1 RAM, 2 shift), bit 17 register select (1 = through storage), bit 16 latch select (1 = latch, 0 = flip-flop), and bits [15:0] table. While `cfg_en` is low, `cfg_din` has no effect.
- R2: In logic mode with the storage bypassed, `cell_out[c]` equals table bit `lut_in[4c+3:4c]` of cell c, combinationally.
- R3: In RAM mode, a rising clock with `tbl_we` high and `cfg_en` low writes `tbl_din[c]` to the table bit at the cell's address. The read is asynchronous, so the new bit appears after that edge and the old bit is seen before it.
- R4: In shift mode, a rising clock with `tbl_we` high moves table bits up by one, and `tbl_din[c]` enters bit 0. The address selects the tap, so address k shows the bit shifted in k+1 enabled clocks earlier.
- R5: The table output is the propagate term. `sum_out[c]` is propagate XOR carry-in. Carry-out equals carry-in when propagate is 1, and equals cell input bit 0 (`lut_in[4c]`) otherwise. Cell 0 takes `cin`, cell 1 takes cell 0's carry-out, and `cout` is cell 1's carry-out.
- R6: `wide_out` shows the table output of cell 1 when `f5_sel` is 1 and of cell 0 when it is 0.
- R7: In flip-flop mode with the register selected, `cell_out[c]` takes the table output on a rising clock when `ce[c]` is high, and holds when `ce[c]` is low.
- R8: In latch mode with the register selected, `cell_out[c]` follows the table output while the clock is high and `ce[c]` is high. It holds while the clock is low or `ce[c]` is low.
- R9: `srst` clears the storage elements to 0 (flip-flop on a rising edge, latch while the clock is high) and leaves tables and control bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the gate of latch-mode storage |
| srst | input | 1 | Synchronous clear of storage elements |
| cfg_en | input | 1 | Serial configuration shift enable |
| cfg_din | input | 1 | Serial configuration data |
| lut_in | input | 8 | Table inputs, 4 per cell, cell c at [4c+3:4c] |
| tbl_we | input | 1 | RAM write enable / shift enable |
| tbl_din | input | 2 | RAM write data or shift data per cell |
| ce | input | 2 | Storage clock enable per cell |
| cin | input | 1 | Carry into cell 0 |
| f5_sel | input | 1 | Wide multiplexer select (fifth input) |
| cell_out | output | 2 | Cell outputs (direct or stored) |
| sum_out | output | 2 | Arithmetic sum bits |
| cout | output | 1 | Carry out of cell 1 |
| wide_out | output | 1 | 5-input function result |

## Verification
The table, sum, carry and wide outputs are combinational, so the bench samples them one time unit after it drives the inputs in the low phase of the clock. Configuration bits, RAM writes, shifts and flip-flop captures take effect at the next rising edge. They are checked shortly after that edge, and RAM reads are also checked just before it to show the old content. Latch results are checked inside the high and low phases, with inputs changed mid-phase. This shows both the transparent and the holding behaviour, and no result depends on the order of events at an edge.

// File: rtl/slice_pkg.sv
package slice_pkg;
   // table operating modes held in the two top bits of each cell word
   typedef enum logic [1:0] {
      TM_LOGIC = 2'd0,
      TM_RAM   = 2'd1,
      TM_SHIFT = 2'd2
   } tbl_mode_e;

   // control bits stored above the table bits: mode(2), reg select, latch select
   localparam int CTRL_BITS = 4;

   function automatic int word_bits(input int k);
      return (1 << k) + CTRL_BITS;
   endfunction
endpackage

// File: rtl/slice_table.sv
module slice_table
   import slice_pkg::*;
#(
   parameter int LUT_K = 4
) (
   input  logic             clk,
   input  logic             cfg_en,
   input  logic             cfg_si,
   output logic             cfg_so,
   input  logic [LUT_K-1:0] addr,
   input  logic             we,
   input  logic             din,
   output logic             lut_o,
   output logic             use_reg_o,
   output logic             latch_o,
   output logic [1:0]       mode_o
);
   localparam int DEPTH = 1 << LUT_K;
   localparam int CW    = word_bits(LUT_K);

   if (DEPTH < 2) begin : g_bad_depth
      $error("slice_table: table depth must be at least 2");
   end

   logic [CW-1:0] word;
   logic          is_ram;
   logic          is_shift;

   assign mode_o    = word[CW-1 -: 2];
   assign use_reg_o = word[CW-3];
   assign latch_o   = word[CW-4];
   assign is_ram    = (mode_o == TM_RAM);
   assign is_shift  = (mode_o == TM_SHIFT);
   assign cfg_so    = word[CW-1];
   assign lut_o     = word[addr];

   always_ff @(posedge clk) begin
      if (cfg_en) begin
         word <= {word[CW-2:0], cfg_si};
      end else if (we && is_ram) begin
         word[addr] <= din;
      end else if (we && is_shift) begin
         word[DEPTH-1:0] <= {word[DEPTH-2:0], din};
      end
   end
endmodule

// File: rtl/slice_carry.sv
module slice_carry (
   input  logic prop,
   input  logic gen_in,
   input  logic cin,
   output logic sum_o,
   output logic cout_o
);
   assign sum_o  = prop ^ cin;
   assign cout_o = prop ? cin : gen_in;
endmodule

// File: rtl/slice_store.sv
module slice_store (
   input  logic clk,
   input  logic srst,
   input  logic ce,
   input  logic d,
   input  logic use_reg,
   input  logic latch_mode,
   output logic q_o
);
   logic ff_q;
   logic lat_q;

   always_ff @(posedge clk) begin
      if (srst) begin
         ff_q <= 1'b0;
      end else if (ce && !latch_mode) begin
         ff_q <= d;
      end
   end

   always_latch begin
      if (clk && (srst || (ce && latch_mode))) begin
         lat_q <= srst ? 1'b0 : d;
      end
   end

   assign q_o = !use_reg ? d : (latch_mode ? lat_q : ff_q);
endmodule

// File: rtl/slice_cell.sv
module slice_cell #(
   parameter int LUT_K = 4
) (
   input  logic             clk,
   input  logic             srst,
   input  logic             cfg_en,
   input  logic             cfg_si,
   output logic             cfg_so,
   input  logic [LUT_K-1:0] a,
   input  logic             we,
   input  logic             din,
   input  logic             ce,
   input  logic             cin,
   output logic             lut_o,
   output logic             cell_o,
   output logic             sum_o,
   output logic             cout_o,
   output logic             use_reg_o,
   output logic             latch_o,
   output logic [1:0]       mode_o
);
   logic prop;

   slice_table #(.LUT_K(LUT_K)) u_table (
      .clk       (clk),
      .cfg_en    (cfg_en),
      .cfg_si    (cfg_si),
      .cfg_so    (cfg_so),
      .addr      (a),
      .we        (we),
      .din       (din),
      .lut_o     (prop),
      .use_reg_o (use_reg_o),
      .latch_o   (latch_o),
      .mode_o    (mode_o)
   );

   slice_carry u_carry (
      .prop   (prop),
      .gen_in (a[0]),
      .cin    (cin),
      .sum_o  (sum_o),
      .cout_o (cout_o)
   );

   slice_store u_store (
      .clk        (clk),
      .srst       (srst),
      .ce         (ce),
      .d          (prop),
      .use_reg    (use_reg_o),
      .latch_mode (latch_o),
      .q_o        (cell_o)
   );

   assign lut_o = prop;
endmodule

// File: rtl/cfg_logic_slice.sv
module cfg_logic_slice #(
   parameter int LUT_K   = 4,
   parameter int N_CELLS = 2
) (
   input  logic                     clk,
   input  logic                     srst,
   input  logic                     cfg_en,
   input  logic                     cfg_din,
   input  logic [N_CELLS*LUT_K-1:0] lut_in,
   input  logic                     tbl_we,
   input  logic [N_CELLS-1:0]       tbl_din,
   input  logic [N_CELLS-1:0]       ce,
   input  logic                     cin,
   input  logic                     f5_sel,
   output logic [N_CELLS-1:0]       cell_out,
   output logic [N_CELLS-1:0]       sum_out,
   output logic                     cout,
   output logic                     wide_out
);
   if (LUT_K < 2 || LUT_K > 6) begin : g_bad_k
      $error("cfg_logic_slice: LUT_K must lie in 2..6");
   end
   if (N_CELLS != 2) begin : g_bad_n
      $error("cfg_logic_slice: the wide multiplexer joins exactly two cells");
   end

   logic [N_CELLS:0]     chain;
   logic [N_CELLS:0]     carry;
   logic [N_CELLS-1:0]   lut_c;
   logic [N_CELLS-1:0]   use_reg_c;
   logic [N_CELLS-1:0]   latch_c;
   logic [2*N_CELLS-1:0] mode_flat;

   assign chain[0] = cfg_din;
   assign carry[0] = cin;

   for (genvar c = 0; c < N_CELLS; c++) begin : g_cell
      slice_cell #(.LUT_K(LUT_K)) u_cell (
         .clk       (clk),
         .srst      (srst),
         .cfg_en    (cfg_en),
         .cfg_si    (chain[c]),
         .cfg_so    (chain[c+1]),
         .a         (lut_in[c*LUT_K +: LUT_K]),
         .we        (tbl_we),
         .din       (tbl_din[c]),
         .ce        (ce[c]),
         .cin       (carry[c]),
         .lut_o     (lut_c[c]),
         .cell_o    (cell_out[c]),
         .sum_o     (sum_out[c]),
         .cout_o    (carry[c+1]),
         .use_reg_o (use_reg_c[c]),
         .latch_o   (latch_c[c]),
         .mode_o    (mode_flat[2*c +: 2])
      );
   end

   assign cout     = carry[N_CELLS];
   assign wide_out = f5_sel ? lut_c[1] : lut_c[0];
endmodule

// File: rtl/slice_chk.sv
module slice_chk #(
   parameter int N_CELLS = 2
) (
   input logic                     clk,
   input logic                     srst,
   input logic                     cfg_en,
   input logic                     tbl_we,
   input logic [N_CELLS-1:0]       ce,
   input logic                     cin,
   input logic                     cout,
   input logic                     wide_out,
   input logic [N_CELLS-1:0]       cell_out,
   input logic [N_CELLS-1:0]       lut_c,
   input logic [N_CELLS-1:0]       use_reg_c,
   input logic [N_CELLS-1:0]       latch_c,
   input logic [2*N_CELLS-1:0]     mode_flat
);
   // R1: control bits move only during a load or a table write
   a_r1_cfg_idle: assert property (@(posedge clk) disable iff (srst)
      (!$past(cfg_en) && !$past(tbl_we)) |->
         ($stable(mode_flat) && $stable(use_reg_c) && $stable(latch_c)));

   // R5: all cells propagating passes the carry straight through
   a_r5_carry_pass: assert property (@(posedge clk) disable iff (srst)
      (&lut_c) |-> (cout == cin));

   // R6: when both tables agree, the wide output carries that value
   a_r6_wide_agree: assert property (@(posedge clk) disable iff (srst)
      (lut_c[0] == lut_c[1]) |-> (wide_out == lut_c[0]));

   for (genvar c = 0; c < N_CELLS; c++) begin : g_cell_chk
      // R7: enabled capture of the table output
      a_r7_ff_capture: assert property (@(posedge clk) disable iff (srst)
         (!$past(srst) && $past(ce[c]) && $past(use_reg_c[c]) && !$past(latch_c[c])
          && use_reg_c[c] && !latch_c[c]) |-> (cell_out[c] == $past(lut_c[c])));

      // R7: hold while the enable is low
      a_r7_ff_hold: assert property (@(posedge clk) disable iff (srst)
         (!$past(srst) && !$past(ce[c]) && $past(use_reg_c[c]) && !$past(latch_c[c])
          && use_reg_c[c] && !latch_c[c]) |-> $stable(cell_out[c]));

      // R9: reset leaves the flip-flop at zero
      a_r9_ff_clear: assert property (@(posedge clk) disable iff (srst)
         ($past(srst) && use_reg_c[c] && !latch_c[c]) |-> (cell_out[c] == 1'b0));
   end
endmodule

bind cfg_logic_slice slice_chk #(.N_CELLS(N_CELLS)) u_slice_chk (
   .clk       (clk),
   .srst      (srst),
   .cfg_en    (cfg_en),
   .tbl_we    (tbl_we),
   .ce        (ce),
   .cin       (cin),
   .cout      (cout),
   .wide_out  (wide_out),
   .cell_out  (cell_out),
   .lut_c     (lut_c),
   .use_reg_c (use_reg_c),
   .latch_c   (latch_c),
   .mode_flat (mode_flat)
);

// File: tb/tb_cfg_logic_slice.sv
module tb_cfg_logic_slice;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       srst;
   logic       cfg_en;
   logic       cfg_din;
   logic [7:0] lut_in;
   logic       tbl_we;
   logic [1:0] tbl_din;
   logic [1:0] ce;
   logic       cin;
   logic       f5_sel;
   logic [1:0] cell_out;
   logic [1:0] sum_out;
   logic       cout;
   logic       wide_out;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   logic [15:0] mt [2];
   logic [1:0]  mq;

   always #(CLK_P/2) clk = ~clk;

   cfg_logic_slice dut (
      .clk(clk), .srst(srst), .cfg_en(cfg_en), .cfg_din(cfg_din),
      .lut_in(lut_in), .tbl_we(tbl_we), .tbl_din(tbl_din), .ce(ce),
      .cin(cin), .f5_sel(f5_sel), .cell_out(cell_out), .sum_out(sum_out),
      .cout(cout), .wide_out(wide_out)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [19:0] mkword(input logic [1:0] mode, input logic rsel,
                                          input logic lsel, input logic [15:0] tbl);
      return {mode, rsel, lsel, tbl};
   endfunction

   // R1: both words sent MSB first, cell1 word first
   task automatic cfg_load(input logic [19:0] w1, input logic [19:0] w0);
      logic [39:0] s;
      s = {w1, w0};
      for (int i = 39; i >= 0; i--) begin
         @(negedge clk);
         cfg_en  = 1'b1;
         cfg_din = s[i];
      end
      @(negedge clk);
      cfg_en = 1'b0;
      mt[1] = w1[15:0];
      mt[0] = w0[15:0];
   endtask

   function automatic logic [15:0] adder_tbl();
      logic [15:0] t;
      for (int i = 0; i < 16; i++) t[i] = i[0] ^ i[1];
      return t;
   endfunction

   task automatic set_addr(input logic [3:0] a1, input logic [3:0] a0);
      lut_in = {a1, a0};
   endtask

   initial begin
      #(CLK_P*100000);
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      logic [3:0] a0, a1;
      logic [1:0] va, vb;
      logic [2:0] tot;
      logic [31:0] seed;
      seed = $urandom(32'h5EED);
      srst = 1'b1; cfg_en = 1'b0; cfg_din = 1'b0; lut_in = '0; tbl_we = 1'b0;
      tbl_din = '0; ce = 2'b11; cin = 1'b0; f5_sel = 1'b0;

      // reset state: storage selected, tables all ones, output must stay 0 under reset
      cfg_load(mkword(2'd0, 1'b1, 1'b0, 16'hFFFF), mkword(2'd0, 1'b1, 1'b0, 16'hFFFF));
      #1 chk("R9 reset clears stored output", {30'd0, cell_out}, 32'd0);
      @(negedge clk);
      srst = 1'b0;
      @(posedge clk); #1;
      chk("R7 first capture after reset", {30'd0, cell_out}, 32'h3);

      // R2 and R6: logic mode with random tables, bypassed storage
      cfg_load(mkword(2'd0, 1'b0, 1'b0, 16'($urandom)), mkword(2'd0, 1'b0, 1'b0, 16'($urandom)));
      for (int k = 0; k < 24; k++) begin
         @(negedge clk);
         a0 = 4'($urandom); a1 = 4'($urandom);
         set_addr(a1, a0);
         f5_sel = 1'($urandom);
         #1;
         chk("R2 logic cell0", {31'd0, cell_out[0]}, {31'd0, mt[0][a0]});
         chk("R2 logic cell1", {31'd0, cell_out[1]}, {31'd0, mt[1][a1]});
         set_addr(a0, a0);
         #1;
         chk("R6 wide function", {31'd0, wide_out}, {31'd0, f5_sel ? mt[1][a0] : mt[0][a0]});
      end

      // R1: serial data with load enable low has no effect
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         cfg_din = 1'($urandom);
      end
      for (int a = 0; a < 16; a++) begin
         @(negedge clk);
         set_addr(4'(15 - a), 4'(a));
         #1;
         chk("R1 idle serial ignored", {30'd0, cell_out},
             {30'd0, mt[1][4'(15 - a)], mt[0][4'(a)]});
      end

      // R3: RAM mode, old value before the edge, new value after it
      cfg_load(mkword(2'd1, 1'b0, 1'b0, 16'h0000), mkword(2'd1, 1'b0, 1'b0, 16'h0000));
      for (int k = 0; k < 30; k++) begin
         @(negedge clk);
         a0 = 4'($urandom); a1 = 4'($urandom);
         set_addr(a1, a0);
         tbl_din = 2'($urandom);
         tbl_we  = 1'($urandom);
         #1 chk("R3 read before write edge", {30'd0, cell_out}, {30'd0, mt[1][a1], mt[0][a0]});
         if (tbl_we) begin
            mt[0][a0] = tbl_din[0];
            mt[1][a1] = tbl_din[1];
         end
         @(posedge clk); #1;
         chk("R3 read after write edge", {30'd0, cell_out}, {30'd0, mt[1][a1], mt[0][a0]});
      end
      @(negedge clk);
      tbl_we = 1'b0;
      for (int a = 0; a < 16; a++) begin
         @(negedge clk);
         set_addr(4'(a), 4'(a));
         #1 chk("R3 RAM content sweep", {30'd0, cell_out}, {30'd0, mt[1][4'(a)], mt[0][4'(a)]});
      end

      // R4: shift mode with random enables and taps
      cfg_load(mkword(2'd2, 1'b0, 1'b0, 16'($urandom)), mkword(2'd2, 1'b0, 1'b0, 16'($urandom)));
      for (int k = 0; k < 24; k++) begin
         @(negedge clk);
         tbl_din = 2'($urandom);
         tbl_we  = 1'($urandom);
         a0 = 4'($urandom); a1 = 4'($urandom);
         set_addr(a1, a0);
         if (tbl_we) begin
            mt[0] = {mt[0][14:0], tbl_din[0]};
            mt[1] = {mt[1][14:0], tbl_din[1]};
         end
         @(posedge clk); #1;
         chk("R4 shift tap", {30'd0, cell_out}, {30'd0, mt[1][a1], mt[0][a0]});
      end
      @(negedge clk);
      tbl_we = 1'b0;
      set_addr(4'd0, 4'd0);
      #1 chk("R4 newest tap at address 0", {30'd0, cell_out}, {30'd0, mt[1][0], mt[0][0]});

      // R5: two-bit adder from propagate tables
      cfg_load(mkword(2'd0, 1'b0, 1'b0, adder_tbl()), mkword(2'd0, 1'b0, 1'b0, adder_tbl()));
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         va = 2'($urandom); vb = 2'($urandom); cin = 1'($urandom);
         if (k == 0) begin va = 2'd3; vb = 2'd0; cin = 1'b1; end
         if (k == 1) begin va = 2'd3; vb = 2'd3; cin = 1'b0; end
         lut_in = {2'b00, vb[1], va[1], 2'b00, vb[0], va[0]};
         tot = 3'(va) + 3'(vb) + 3'(cin);
         #1;
         chk("R5 sum bits", {30'd0, sum_out}, {30'd0, tot[1:0]});
         chk("R5 carry out", {31'd0, cout}, {31'd0, tot[2]});
      end

      // R7: flip-flop mode with random enables
      cfg_load(mkword(2'd0, 1'b1, 1'b0, 16'($urandom)), mkword(2'd0, 1'b1, 1'b0, 16'($urandom)));
      @(negedge clk);
      ce = 2'b11; set_addr(4'd0, 4'd0);
      @(posedge clk); #1;
      mq = {mt[1][0], mt[0][0]};
      chk("R7 loaded capture", {30'd0, cell_out}, {30'd0, mq});
      for (int k = 0; k < 24; k++) begin
         @(negedge clk);
         a0 = 4'($urandom); a1 = 4'($urandom);
         set_addr(a1, a0);
         ce = 2'($urandom);
         #1 chk("R7 stable between edges", {30'd0, cell_out}, {30'd0, mq});
         if (ce[0]) mq[0] = mt[0][a0];
         if (ce[1]) mq[1] = mt[1][a1];
         @(posedge clk); #1;
         chk("R7 edge capture or hold", {30'd0, cell_out}, {30'd0, mq});
      end

      // R9: reset with enable low clears storage, tables survive
      @(negedge clk);
      ce = 2'b00; srst = 1'b1;
      @(posedge clk); #1;
      chk("R9 flip-flop cleared", {30'd0, cell_out}, 32'd0);
      @(negedge clk);
      srst = 1'b0; ce = 2'b11;
      for (int a = 0; a < 16; a++) begin
         @(negedge clk);
         set_addr(4'(a), 4'(a));
         @(posedge clk); #1;
         chk("R9 tables kept over reset", {30'd0, cell_out}, {30'd0, mt[1][4'(a)], mt[0][4'(a)]});
      end

      // R8: latch mode, table 00FF (address below 8 gives 1)
      cfg_load(mkword(2'd0, 1'b1, 1'b1, 16'h00FF), mkword(2'd0, 1'b1, 1'b1, 16'h00FF));
      ce = 2'b11; set_addr(4'd0, 4'd0);
      @(posedge clk); #2;
      chk("R8 transparent high phase", {30'd0, cell_out}, 32'h3);
      set_addr(4'd9, 4'd9);
      #1 chk("R8 follows while high", {30'd0, cell_out}, 32'h0);
      @(negedge clk); #2;
      set_addr(4'd0, 4'd0);
      #1 chk("R8 holds while low", {30'd0, cell_out}, 32'h0);
      @(posedge clk); #2;
      chk("R8 opens at high phase", {30'd0, cell_out}, 32'h3);
      ce = 2'b01;
      #1 set_addr(4'd9, 4'd9);
      #1 chk("R8 enable low holds cell1", {30'd0, cell_out}, 32'h2);
      @(negedge clk); #2;
      srst = 1'b1; ce = 2'b00;
      @(posedge clk); #2;
      chk("R9 latch cleared in high phase", {30'd0, cell_out}, 32'h0);
      @(negedge clk);
      srst = 1'b0; ce = 2'b11; set_addr(4'd3, 4'd3);
      @(posedge clk); #2;
      chk("R8 reopens after reset", {30'd0, cell_out}, 32'h3);

      @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule